// File: doc/BRIEF.md
# I2C Master STOP Sequencer

This block closes an I2C master transfer with a STOP condition. Once a byte has been moved and the ninth clock has left SCL low, software raises a stop request. The block then pulls SDA low, lets SCL float high, and finally lets SDA float high. Each step is timed by an external reload/count-down rate generator. The block pulses `rg_load` to restart the generator and advances on its `rg_tick` overflow.

The lines are open-drain. The block only drives a pull-low enable for each line and reads the bus level back through a synchronizer. Every edge it releases is confirmed at its new sampled level before the generator is reloaded. As a result, a slave that stretches SCL, or a device that holds SDA, simply pauses the sequence.

When both lines are sampled high, a sticky stop-seen flag is set. One generator period later, the stop-enable indication clears and a sticky interrupt flag is raised. While a sequence is running, writes to the transmit buffer are refused and reported through a sticky collision flag.

Top module: `i2c_stop_seq`

## Requirements
- R1: After reset, both pull-low outputs are 0 (lines released). `stop_en`, `rg_load`, `stop_seen`, `wcol` and `irq` are 0, and `tx_buf` is 0.
- R2: A one-cycle `stop_req` in idle makes `stop_en`, `sda_pull_low` and `scl_pull_low` all 1 from the next clock edge.
- R3: `rg_load` is a single-cycle pulse. The first pulse of a sequence comes only once SDA has been sampled low through the SYNC_STAGES-flop synchronizer, which is SYNC_STAGES+1 cycles after R2's outputs appear.
- R4: `scl_pull_low` drops to 0 on the clock edge after the first `rg_tick` that follows the first `rg_load`. A `rg_tick` while idle changes no output.
- R5: After SCL is released, the next `rg_load` waits until SCL is sampled high. While SCL is held low externally, no `rg_load` occurs and no `rg_tick` advances the sequence.
- R6: `sda_pull_low` drops only on an `rg_tick` after the second `rg_load`, and SDA is never released while `scl_pull_low` is 1.
- R7: `stop_seen` becomes 1 only when SDA and SCL are both sampled high after SDA was released. It stays 1 until a `stop_seen_clr` pulse.
- R8: One generator period after `stop_seen` is set, `stop_en` returns to 0, both lines are released, and `irq` becomes 1. `irq` stays 1 until `irq_clr`.
- R9: A `buf_wr` while `stop_en` is 1 leaves `tx_buf` unchanged and sets `wcol`. `wcol` stays 1 until `wcol_clr`.
- R10: A `buf_wr` while idle loads `buf_wdata` into `tx_buf` on that edge and leaves `wcol` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronous release |
| stop_req | input | 1 | Software pulse requesting a STOP |
| stop_en | output | 1 | High while the STOP request is pending |
| scl_i | input | 1 | Raw SCL bus level |
| sda_i | input | 1 | Raw SDA bus level |
| scl_pull_low | output | 1 | Open-drain enable pulling SCL low |
| sda_pull_low | output | 1 | Open-drain enable pulling SDA low |
| rg_load | output | 1 | One-cycle reload pulse to the rate generator |
| rg_tick | input | 1 | Rate generator overflow pulse |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | DATA_W | Transmit buffer write data |
| tx_buf | output | DATA_W | Transmit buffer contents |
| stop_seen | output | 1 | Sticky STOP-detected flag |
| stop_seen_clr | input | 1 | Clears `stop_seen` |
| wcol | output | 1 | Sticky write-collision flag |
| wcol_clr | input | 1 | Clears `wcol` |
| irq | output | 1 | Sticky interrupt flag |
| irq_clr | input | 1 | Clears `irq` |

## Verification
The bench builds the block with DATA_W = 8 and SYNC_STAGES = 2, and pairs it with a behavioural rate generator that reloads to 3. A full STOP therefore completes in about twenty cycles, which makes the exact cycle of the first reload and of the SCL release checkable. The bench's wired-AND bus model lets it hold SCL or SDA low from outside. That brings clock stretching, a held SDA line and stray overflow pulses within reach of short directed runs.

// File: rtl/i2c_stop_pkg.sv
package i2c_stop_pkg;

  // Sequencer phases; order follows the bus sequence.
  typedef enum logic [2:0] {
    ST_IDLE      = 3'd0,
    ST_HOLD_SDA  = 3'd1,
    ST_CNT_SETUP = 3'd2,
    ST_SCL_RISE  = 3'd3,
    ST_CNT_HIGH  = 3'd4,
    ST_SDA_RISE  = 3'd5,
    ST_CNT_TAIL  = 3'd6
  } stop_state_e;

  localparam int unsigned BUS_LINES = 2;
  localparam int unsigned LINE_SCL  = 0;
  localparam int unsigned LINE_SDA  = 1;

endpackage

// File: rtl/i2c_stop_sync.sv
module i2c_stop_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] din,
  output logic [LINES-1:0] dout
);

  // Idle bus level is high, so stages reset to all ones.
  logic [LINES-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    logic [LINES-1:0] stage_d;
    if (g == 0) begin : g_first
      assign stage_d = din;
    end else begin : g_next
      assign stage_d = stage_q[g-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stage_q[g] <= '1;
      else        stage_q[g] <= stage_d;
    end
  end

  assign dout = stage_q[STAGES-1];

endmodule

// File: rtl/i2c_stop_fsm.sv
module i2c_stop_fsm
  import i2c_stop_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic scl_hi,
  input  logic sda_hi,
  input  logic rg_tick,
  output logic scl_pull_low,
  output logic sda_pull_low,
  output logic rg_load,
  output logic stop_en,
  output logic busy,
  output logic evt_stop_seen,
  output logic evt_done
);

  stop_state_e state_q, state_d;
  logic        load_d;
  logic        scl_low_d, sda_low_d, stop_en_d;
  logic        scl_low_q, sda_low_q, load_q, stop_en_q;

  // Next-state logic
  always_comb begin
    state_d       = state_q;
    load_d        = 1'b0;
    evt_stop_seen = 1'b0;
    evt_done      = 1'b0;
    unique case (state_q)
      ST_IDLE:
        if (stop_req) state_d = ST_HOLD_SDA;
      ST_HOLD_SDA:
        if (!sda_hi) begin
          state_d = ST_CNT_SETUP;
          load_d  = 1'b1;
        end
      ST_CNT_SETUP:
        if (rg_tick) state_d = ST_SCL_RISE;
      ST_SCL_RISE:
        if (scl_hi) begin
          state_d = ST_CNT_HIGH;
          load_d  = 1'b1;
        end
      ST_CNT_HIGH:
        if (rg_tick) state_d = ST_SDA_RISE;
      ST_SDA_RISE:
        if (sda_hi && scl_hi) begin
          state_d       = ST_CNT_TAIL;
          load_d        = 1'b1;
          evt_stop_seen = 1'b1;
        end
      ST_CNT_TAIL:
        if (rg_tick) begin
          state_d  = ST_IDLE;
          evt_done = 1'b1;
        end
      default: state_d = ST_IDLE;
    endcase
  end

  // Registered pin drives follow the next phase so the pads never glitch
  always_comb begin
    scl_low_d = (state_d == ST_HOLD_SDA) || (state_d == ST_CNT_SETUP);
    sda_low_d = (state_d == ST_HOLD_SDA) || (state_d == ST_CNT_SETUP) ||
                (state_d == ST_SCL_RISE) || (state_d == ST_CNT_HIGH);
    stop_en_d = stop_en_q;
    if (state_q == ST_IDLE && stop_req) stop_en_d = 1'b1;
    else if (evt_done)                  stop_en_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      scl_low_q <= 1'b0;
      sda_low_q <= 1'b0;
      load_q    <= 1'b0;
      stop_en_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      scl_low_q <= scl_low_d;
      sda_low_q <= sda_low_d;
      load_q    <= load_d;
      stop_en_q <= stop_en_d;
    end
  end

  assign scl_pull_low = scl_low_q;
  assign sda_pull_low = sda_low_q;
  assign rg_load      = load_q;
  assign stop_en      = stop_en_q;
  assign busy         = (state_q != ST_IDLE);

  // R3: the reload strobe never lasts more than one cycle
  assert_load_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
    rg_load |=> !rg_load);

  // R4: SCL is only released right after a generator overflow
  assert_scl_release_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scl_pull_low) |-> $past(rg_tick));

  // R5: no reload while waiting for a stretched SCL to read high
  assert_wait_scl_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_SCL_RISE && !scl_hi) |=> !rg_load);

  // R6: SDA is only released right after a generator overflow
  assert_sda_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sda_pull_low) |-> $past(rg_tick));

endmodule

// File: rtl/i2c_stop_flags.sv
module i2c_stop_flags #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              evt_stop_seen,
  input  logic              evt_done,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              stop_seen_clr,
  input  logic              wcol_clr,
  input  logic              irq_clr,
  output logic [DATA_W-1:0] tx_buf,
  output logic              stop_seen,
  output logic              wcol,
  output logic              irq
);

  logic [DATA_W-1:0] buf_q;
  logic              buf_en;
  logic              seen_q, seen_d;
  logic              wcol_q, wcol_d;
  logic              irq_q, irq_d;

  // A set event wins over a clear in the same cycle.
  always_comb begin
    buf_en = buf_wr && !busy;
    seen_d = evt_stop_seen     || (seen_q && !stop_seen_clr);
    wcol_d = (buf_wr && busy)  || (wcol_q && !wcol_clr);
    irq_d  = evt_done          || (irq_q  && !irq_clr);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      seen_q <= 1'b0;
      wcol_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      seen_q <= seen_d;
      wcol_q <= wcol_d;
      irq_q  <= irq_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      buf_q <= '0;
    else if (buf_en) buf_q <= buf_wdata;
  end

  assign tx_buf    = buf_q;
  assign stop_seen = seen_q;
  assign wcol      = wcol_q;
  assign irq       = irq_q;

  // R9: a refused write flags a collision and leaves the buffer alone
  assert_wcol_refuse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && buf_wr) |=> (wcol && $stable(tx_buf)));

  // R10: an idle write lands in the buffer
  assert_buf_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && buf_wr) |=> (tx_buf == $past(buf_wdata)));

  // R7: stop-seen holds until cleared
  assert_seen_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_seen && !stop_seen_clr) |=> stop_seen);

  // R8: interrupt holds until cleared
  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq && !irq_clr) |=> irq);

endmodule

// File: rtl/i2c_stop_seq.sv
module i2c_stop_seq
  import i2c_stop_pkg::*;
#(
  parameter int unsigned DATA_W      = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stop_req,
  output logic              stop_en,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              scl_pull_low,
  output logic              sda_pull_low,
  output logic              rg_load,
  input  logic              rg_tick,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  output logic [DATA_W-1:0] tx_buf,
  output logic              stop_seen,
  input  logic              stop_seen_clr,
  output logic              wcol,
  input  logic              wcol_clr,
  output logic              irq,
  input  logic              irq_clr
);

  logic [BUS_LINES-1:0] bus_raw, bus_sync;
  logic                 busy, evt_stop_seen, evt_done;

  assign bus_raw[LINE_SCL] = scl_i;
  assign bus_raw[LINE_SDA] = sda_i;

  i2c_stop_sync #(
    .STAGES (SYNC_STAGES),
    .LINES  (BUS_LINES)
  ) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .din   (bus_raw),
    .dout  (bus_sync)
  );

  i2c_stop_fsm u_fsm (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .scl_hi        (bus_sync[LINE_SCL]),
    .sda_hi        (bus_sync[LINE_SDA]),
    .rg_tick       (rg_tick),
    .scl_pull_low  (scl_pull_low),
    .sda_pull_low  (sda_pull_low),
    .rg_load       (rg_load),
    .stop_en       (stop_en),
    .busy          (busy),
    .evt_stop_seen (evt_stop_seen),
    .evt_done      (evt_done)
  );

  i2c_stop_flags #(
    .DATA_W (DATA_W)
  ) u_flags (
    .clk           (clk),
    .rst_n         (rst_n),
    .busy          (busy),
    .evt_stop_seen (evt_stop_seen),
    .evt_done      (evt_done),
    .buf_wr        (buf_wr),
    .buf_wdata     (buf_wdata),
    .stop_seen_clr (stop_seen_clr),
    .wcol_clr      (wcol_clr),
    .irq_clr       (irq_clr),
    .tx_buf        (tx_buf),
    .stop_seen     (stop_seen),
    .wcol          (wcol),
    .irq           (irq)
  );

  // R6: SCL may only be held low while SDA is also held low
  assert_line_order_R6: assert property (@(posedge clk) disable iff (!rst_n)
    scl_pull_low |-> sda_pull_low);

  // R8: the interrupt rises on the same edge the request indication drops
  assert_irq_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $fell(stop_en));

  // R1: lines are released whenever no STOP is pending
  assert_idle_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_en |-> (!scl_pull_low && !sda_pull_low));

endmodule

// File: tb/i2c_stop_seq_bench.sv
module i2c_stop_seq_bench;

  localparam int DATA_W      = 8;
  localparam int SYNC_STAGES = 2;
  localparam int RELOAD      = 3;
  localparam int TMO         = 200;

  logic clk = 1'b0;
  logic rst_n;
  logic stop_req, stop_en;
  logic scl_i, sda_i, scl_pull_low, sda_pull_low;
  logic rg_load, rg_tick;
  logic buf_wr;
  logic [DATA_W-1:0] buf_wdata, tx_buf;
  logic stop_seen, stop_seen_clr, wcol, wcol_clr, irq, irq_clr;
  logic ext_scl_low, ext_sda_low, stray_tick;
  logic [3:0] rcnt;

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  // Wired-AND bus with optional external holders
  assign scl_i = !(scl_pull_low || ext_scl_low);
  assign sda_i = !(sda_pull_low || ext_sda_low);

  // Behavioural rate generator
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           rcnt <= '0;
    else if (rg_load)     rcnt <= 4'(RELOAD);
    else if (rcnt != 0)   rcnt <= rcnt - 4'd1;
  end
  assign rg_tick = (rcnt == 4'd1) || stray_tick;

  i2c_stop_seq #(
    .DATA_W      (DATA_W),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_i2c_stop_seq (
    .clk           (clk),
    .rst_n         (rst_n),
    .stop_req      (stop_req),
    .stop_en       (stop_en),
    .scl_i         (scl_i),
    .sda_i         (sda_i),
    .scl_pull_low  (scl_pull_low),
    .sda_pull_low  (sda_pull_low),
    .rg_load       (rg_load),
    .rg_tick       (rg_tick),
    .buf_wr        (buf_wr),
    .buf_wdata     (buf_wdata),
    .tx_buf        (tx_buf),
    .stop_seen     (stop_seen),
    .stop_seen_clr (stop_seen_clr),
    .wcol          (wcol),
    .wcol_clr      (wcol_clr),
    .irq           (irq),
    .irq_clr       (irq_clr)
  );

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic clear_flags();
    @(negedge clk);
    stop_seen_clr = 1; wcol_clr = 1; irq_clr = 1;
    @(negedge clk);
    stop_seen_clr = 0; wcol_clr = 0; irq_clr = 0;
  endtask

  task automatic pulse_req();
    @(negedge clk);
    stop_req = 1;
    @(negedge clk);
    stop_req = 0;
  endtask

  task automatic wait_done(input string req);
    for (int n = 0; n < TMO && stop_en; n++) @(negedge clk);
    chk(req, "sequence finished", stop_en, 0);
  endtask

  task automatic t_reset();
    chk("R1", "scl_pull_low", scl_pull_low, 0);
    chk("R1", "sda_pull_low", sda_pull_low, 0);
    chk("R1", "stop_en", stop_en, 0);
    chk("R1", "rg_load", rg_load, 0);
    chk("R1", "flags", {stop_seen, wcol, irq}, 0);
    chk("R1", "tx_buf", tx_buf, 0);
  endtask

  task automatic t_idle_tick();
    @(negedge clk); stray_tick = 1;
    @(negedge clk); stray_tick = 0;
    repeat (3) @(negedge clk);
    chk("R4", "idle tick stop_en", stop_en, 0);
    chk("R4", "idle tick lines", {scl_pull_low, sda_pull_low}, 0);
    chk("R4", "idle tick irq/load", {irq, rg_load}, 0);
  endtask

  task automatic t_buf_idle();
    @(negedge clk); buf_wr = 1; buf_wdata = 8'h33;
    @(negedge clk); buf_wr = 0;
    chk("R10", "tx_buf after idle write", tx_buf, 8'h33);
    chk("R10", "wcol after idle write", wcol, 0);
  endtask

  task automatic t_basic();
    pulse_req();
    chk("R2", "scl_pull_low", scl_pull_low, 1);
    chk("R2", "sda_pull_low", sda_pull_low, 1);
    chk("R2", "stop_en", stop_en, 1);
    for (int k = 0; k < SYNC_STAGES; k++) begin
      @(negedge clk);
      chk("R3", "early rg_load", rg_load, 0);
    end
    @(negedge clk);
    chk("R3", "rg_load after sync", rg_load, 1);
    @(negedge clk);
    chk("R3", "rg_load one cycle", rg_load, 0);
    for (int k = 0; k < RELOAD - 1; k++) begin
      @(negedge clk);
      chk("R4", "scl held before tick", scl_pull_low, 1);
    end
    @(negedge clk);
    chk("R4", "scl released after tick", scl_pull_low, 0);
    chk("R6", "sda held at scl release", sda_pull_low, 1);
    for (int n = 0; n < TMO && sda_pull_low; n++) @(negedge clk);
    chk("R6", "sda released", sda_pull_low, 0);
    for (int n = 0; n < TMO && !stop_seen; n++) @(negedge clk);
    chk("R7", "stop_seen set", stop_seen, 1);
    chk("R8", "stop_en still high at stop_seen", stop_en, 1);
    chk("R8", "irq not early", irq, 0);
    wait_done("R8");
    chk("R8", "irq at end", irq, 1);
    chk("R8", "lines released at end", {scl_pull_low, sda_pull_low}, 0);
    repeat (5) @(negedge clk);
    chk("R7", "stop_seen sticky", stop_seen, 1);
    chk("R8", "irq sticky", irq, 1);
    clear_flags();
    chk("R7", "stop_seen cleared", stop_seen, 0);
    chk("R8", "irq cleared", irq, 0);
  endtask

  task automatic t_stretch();
    ext_scl_low = 1;
    pulse_req();
    for (int n = 0; n < TMO && scl_pull_low; n++) @(negedge clk);
    chk("R5", "master released scl", scl_pull_low, 0);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (k == 5) stray_tick = 1;
      if (k == 6) stray_tick = 0;
      if (rg_load) chk("R5", "no reload while stretched", rg_load, 0);
    end
    chk("R5", "sda held while stretched", sda_pull_low, 1);
    chk("R5", "stop_seen not set while stretched", stop_seen, 0);
    ext_scl_low = 0;
    for (int n = 0; n < SYNC_STAGES + 3 && !rg_load; n++) @(negedge clk);
    chk("R5", "reload after scl high", rg_load, 1);
    wait_done("R5");
    chk("R8", "irq after stretched stop", irq, 1);
    clear_flags();
  endtask

  task automatic t_sda_hold();
    ext_sda_low = 1;
    pulse_req();
    for (int n = 0; n < TMO && sda_pull_low; n++) @(negedge clk);
    chk("R7", "master released sda", sda_pull_low, 0);
    repeat (20) @(negedge clk);
    chk("R7", "no stop_seen while sda held", stop_seen, 0);
    chk("R7", "stop_en held while sda held", stop_en, 1);
    ext_sda_low = 0;
    for (int n = 0; n < TMO && !stop_seen; n++) @(negedge clk);
    chk("R7", "stop_seen after sda high", stop_seen, 1);
    wait_done("R7");
    clear_flags();
  endtask

  task automatic t_wcol();
    pulse_req();
    repeat (3) @(negedge clk);
    buf_wr = 1; buf_wdata = 8'h5A;
    @(negedge clk); buf_wr = 0;
    chk("R9", "tx_buf unchanged", tx_buf, 8'h33);
    chk("R9", "wcol set", wcol, 1);
    wait_done("R9");
    chk("R9", "wcol sticky", wcol, 1);
    chk("R9", "tx_buf after stop", tx_buf, 8'h33);
    clear_flags();
    chk("R9", "wcol cleared", wcol, 0);
  endtask

  initial begin
    #(4 * 150000);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected done");
      $display("[TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end

  initial begin
    rst_n = 0; stop_req = 0; buf_wr = 0; buf_wdata = '0;
    stop_seen_clr = 0; wcol_clr = 0; irq_clr = 0;
    ext_scl_low = 0; ext_sda_low = 0; stray_tick = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_idle_tick();
    t_buf_idle();
    t_basic();
    t_stretch();
    t_sda_hold();
    t_wcol();
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

endmodule